// File: doc/BRIEF.md
# Flash Program/Erase Sequencer

This block is the embedded controller that carries out a single word program or a single block erase on a small behavioural flash array that it contains. A host hands it one command at a time over a valid/ready interface, with an opcode, a 17-bit word address and a data word. The sequencer maps the address onto one of five erase blocks of unequal size, and checks the write-protect conditions. It then runs a pulse-and-verify loop, where each pulse lasts a fixed number of clock cycles and a verify step follows every pulse. An erase can be suspended and later resumed. A loss of the programming supply, or a power-down level on the reset pin, aborts the operation in progress.

Supply and pin levels arrive as digital flags. `rp_lvl` encodes the reset/power-down pin: 0 means power-down, 1 means normal high, 2 means elevated unlock, and 3 is treated as normal. `cmd_op` is 2'b01 for program and 2'b10 for erase. Other codes are accepted and have no effect. The status byte is built as follows:

- bit 7: ready
- bit 6: erase suspended
- bit 5: erase error
- bit 4: program error
- bit 3: programming-supply fault
- bits 2:0: always zero

The array keeps `WPB` words per block, selected by the low address bits. It stays small, and an asynchronous read port shows its contents.

Back-pressure rule: a command is taken on a clock edge where both `cmd_valid` and `cmd_ready` are high. The host holds `cmd_op`, `cmd_addr` and `cmd_data` stable while `cmd_valid` is high and `cmd_ready` is low. `cmd_ready` is high only when the sequencer is idle (not busy and not suspended) and `rp_lvl` is not power-down.

Top module: `pe_sequencer`

## Requirements
- R1: After reset the status reads 0x80, `cmd_ready` is 1 and every array word reads all ones.
- R2: Block decode by word address:
  - block 0: 00000h-01FFFh
  - block 1: 02000h-02FFFh
  - block 2: 03000h-03FFFh
  - block 3: 04000h-0FFFFh
  - block 4: 10000h-1FFFFh
  
  Only block 0 is subject to boot protection, so 01FFFh is locked when 02000h is not.
- R3: A command is refused at once, leaving the array unchanged and the sequencer idle, in two cases:
  - it targets block 0 while `rp_lvl` is normal and `wp` is 0;
  - the supply is low.
  
  A refusal for protection sets bit 4 for a program and bit 5 for an erase. With `wp`=1 or `rp_lvl`=2, block 0 is writable.
- R4: A program pulse stores old AND new data, so bits only go from 1 to 0. A program whose word then equals the data ends with status 0x80.
- R5: A program whose data needs a 0-to-1 change fails after `PROG_MAX` pulses. It ends with status 0x90, and the word holds old AND data.
- R6: A successful erase sets every word of the addressed block to all ones, ends with status 0x80 and leaves other blocks untouched.
- R7: Each erase pulse restores the lowest-indexed word of the block that is not all ones. An erase still unverified after `ERASE_MAX` pulses ends with status 0xA0.
- R8: With `vpp_ok`=0 at acceptance, or during a running operation, the operation ends at the next edge with status 0x88. An abort that comes before the first pulse ends leaves the array unchanged.
- R9: `suspend_req` during an erase gives status 0xC0 at the next edge, and no pulse is applied in that cycle. If the request arrives in the final verify cycle of an erase that verifies, the erase completes and status reads 0x80.
- R10: `resume_req` while suspended clears bit 6 and restarts pulsing (status 0x00). The pulse count is kept, and the erase then completes.
- R11: While suspended, `vpp_ok`=0 or `rp_lvl`=0 aborts the erase: the sequencer goes idle with bits 5 and 3 set (status 0xA8).
- R12: Bits 5 to 3 are never cleared by a later operation. A `clr_status` pulse clears them.
- R13: `cmd_ready` is 0 while busy, while suspended and while `rp_lvl` is power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_op | input | 2 | 01 program, 10 erase |
| cmd_addr | input | 17 | Word address |
| cmd_data | input | DATA_W | Program data |
| suspend_req | input | 1 | Suspend a running erase |
| resume_req | input | 1 | Resume a suspended erase |
| clr_status | input | 1 | Clear status bits 5 to 3 |
| vpp_ok | input | 1 | Programming supply at valid level |
| rp_lvl | input | 2 | Reset/power-down pin level |
| wp | input | 1 | Write-protect pin |
| status | output | 8 | Status byte |
| rd_addr | input | 17 | Array read address |
| rd_data | output | DATA_W | Array read data |

## Verification
The assertions check the following on every cycle:
- each program pulse yields old AND data;
- at most one array action happens at a time;
- error bits stay set unless cleared;
- a supply loss during a run or a suspension always lands idle with the right error bits;
- only an erase can be suspended;
- the pulse count never passes its limit;
- `cmd_ready` implies ready and not suspended.

Only the bench scenarios can show the block-boundary decode, the lowest-word-first erase progress, the suspend that arrives in the final verify cycle, and that resumed erases finish with the array fully erased.

// File: rtl/pe_pkg.sv
package pe_pkg;
  localparam int ADDR_W = 17;
  localparam int NBLK   = 5;
  localparam int BLK_W  = 3;

  localparam logic [1:0] RP_OFF  = 2'd0;
  localparam logic [1:0] RP_NORM = 2'd1;
  localparam logic [1:0] RP_UNLK = 2'd2;

  localparam logic [1:0] OP_PROG  = 2'b01;
  localparam logic [1:0] OP_ERASE = 2'b10;

  // error vector bit order: [2] erase error, [1] program error, [0] supply fault
  localparam logic [2:0] ERR_ERASE = 3'b100;
  localparam logic [2:0] ERR_PROG  = 3'b010;
  localparam logic [2:0] ERR_VPP   = 3'b001;

  typedef enum logic [1:0] {ST_IDLE, ST_PULSE, ST_VERIFY, ST_SUSP} seq_st_e;

  function automatic logic [BLK_W-1:0] blk_of(input logic [ADDR_W-1:0] a);
    if (a[16])              return 3'd4;
    else if (a[15:14] != 0) return 3'd3;
    else if (a[13])         return a[12] ? 3'd2 : 3'd1;
    else                    return 3'd0;
  endfunction
endpackage

// File: rtl/pe_block_map.sv
module pe_block_map
  import pe_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              vpp_ok,
  input  logic [1:0]        rp_lvl,
  input  logic              wp,
  output logic [BLK_W-1:0]  blk,
  output logic              prot
);
  logic boot_locked;

  assign blk         = blk_of(addr);
  assign boot_locked = (rp_lvl != RP_UNLK) && !wp;
  assign prot        = !vpp_ok || ((blk == 3'd0) && boot_locked);
endmodule

// File: rtl/pe_array.sv
module pe_array
  import pe_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int WPB    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BLK_W-1:0]  op_blk,
  input  logic [$clog2(WPB)-1:0] op_widx,
  input  logic [DATA_W-1:0] op_data,
  input  logic              prog_en,
  input  logic              erase_en,
  output logic [DATA_W-1:0] word_q,
  output logic              blk_erased,
  input  logic [BLK_W-1:0]  rd_blk,
  input  logic [$clog2(WPB)-1:0] rd_widx,
  output logic [DATA_W-1:0] rd_q
);
  localparam int DEPTH = NBLK * WPB;
  localparam int IDX_W = $clog2(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [IDX_W-1:0]  op_idx, rd_idx, fix_idx;
  logic              fix_hit;
  int                base;

  assign op_idx = IDX_W'(int'(op_blk) * WPB + int'(op_widx));
  assign rd_idx = IDX_W'(int'(rd_blk) * WPB + int'(rd_widx));
  assign word_q = mem[op_idx];
  assign rd_q   = mem[rd_idx];

  // find whether the block is clean and which word the next erase pulse restores
  always_comb begin
    base       = int'(op_blk) * WPB;
    blk_erased = 1'b1;
    fix_hit    = 1'b0;
    fix_idx    = '0;
    for (int i = 0; i < WPB; i++) begin
      if (mem[IDX_W'(base + i)] != '1) begin
        blk_erased = 1'b0;
        if (!fix_hit) begin
          fix_hit = 1'b1;
          fix_idx = IDX_W'(base + i);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (prog_en) begin
      mem[op_idx] <= mem[op_idx] & op_data;
    end else if (erase_en && fix_hit) begin
      mem[fix_idx] <= '1;
    end
  end

  a_r4_and_only: assert property (@(posedge clk) disable iff (!rst_n)
    prog_en |=> word_q == ($past(word_q) & $past(op_data)));
  a_r7_single_action: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prog_en, erase_en}));
endmodule

// File: rtl/pe_ctrl.sv
module pe_ctrl
  import pe_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int WIDX_W    = 2,
  parameter int PULSE_CYC = 4,
  parameter int PROG_MAX  = 5,
  parameter int ERASE_MAX = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [BLK_W-1:0]  cmd_blk,
  input  logic [WIDX_W-1:0] cmd_widx,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic              cmd_prot,
  input  logic              suspend_req,
  input  logic              resume_req,
  input  logic              clr_status,
  input  logic              vpp_ok,
  input  logic [1:0]        rp_lvl,
  input  logic [DATA_W-1:0] word_q,
  input  logic              blk_erased,
  output logic [BLK_W-1:0]  op_blk,
  output logic [WIDX_W-1:0] op_widx,
  output logic [DATA_W-1:0] op_data,
  output logic              prog_en,
  output logic              erase_en,
  output logic [7:0]        status
);
  localparam int MAXP = (PROG_MAX > ERASE_MAX) ? PROG_MAX : ERASE_MAX;
  localparam int PC_W = $clog2(MAXP + 1);
  localparam int CC_W = $clog2(PULSE_CYC + 1);
  localparam logic [CC_W-1:0] CC_LAST  = CC_W'(PULSE_CYC - 1);
  localparam logic [PC_W-1:0] LIM_PROG = PC_W'(PROG_MAX);
  localparam logic [PC_W-1:0] LIM_ERS  = PC_W'(ERASE_MAX);

  seq_st_e           st_q, st_d;
  logic              erase_q;
  logic [CC_W-1:0]   ccnt_q, ccnt_d;
  logic [PC_W-1:0]   pcnt_q, pcnt_d;
  logic [2:0]        err_q, err_set;
  logic              pwr_off, accept, cmd_known, running, verify_ok, susp_e, pulse_end;
  logic [PC_W-1:0]   limit;
  logic [2:0]        op_bit;

  assign pwr_off   = (rp_lvl == RP_OFF);
  assign cmd_ready = (st_q == ST_IDLE) && !pwr_off;
  assign accept    = cmd_valid && cmd_ready;
  assign cmd_known = (cmd_op == OP_PROG) || (cmd_op == OP_ERASE);
  assign running   = (st_q == ST_PULSE) || (st_q == ST_VERIFY);
  assign verify_ok = erase_q ? blk_erased : (word_q == op_data);
  assign limit     = erase_q ? LIM_ERS : LIM_PROG;
  assign op_bit    = erase_q ? ERR_ERASE : ERR_PROG;
  assign susp_e    = erase_q && suspend_req;
  assign pulse_end = (st_q == ST_PULSE) && (ccnt_q == CC_LAST) && !pwr_off && vpp_ok;
  assign prog_en   = pulse_end && !erase_q;
  assign erase_en  = pulse_end && erase_q && !suspend_req;

  always_comb begin
    st_d    = st_q;
    ccnt_d  = ccnt_q;
    pcnt_d  = pcnt_q;
    err_set = '0;
    unique case (st_q)
      ST_IDLE: if (accept && cmd_known) begin
        if (!vpp_ok)       err_set = ERR_VPP;
        else if (cmd_prot) err_set = (cmd_op == OP_ERASE) ? ERR_ERASE : ERR_PROG;
        else begin
          st_d   = ST_PULSE;
          ccnt_d = '0;
          pcnt_d = '0;
        end
      end
      ST_PULSE, ST_VERIFY: begin
        if (pwr_off) begin
          err_set = op_bit;
          st_d    = ST_IDLE;
        end else if (!vpp_ok) begin
          err_set = ERR_VPP;
          st_d    = ST_IDLE;
        end else if (st_q == ST_VERIFY) begin
          if (verify_ok) st_d = ST_IDLE;
          else if (pcnt_q == limit) begin
            err_set = op_bit;
            st_d    = ST_IDLE;
          end else if (susp_e) st_d = ST_SUSP;
          else begin
            st_d   = ST_PULSE;
            ccnt_d = '0;
          end
        end else if (susp_e) begin
          st_d = ST_SUSP;
        end else if (ccnt_q == CC_LAST) begin
          pcnt_d = pcnt_q + 1'b1;
          st_d   = ST_VERIFY;
        end else begin
          ccnt_d = ccnt_q + 1'b1;
        end
      end
      ST_SUSP: begin
        if (pwr_off || !vpp_ok) begin
          err_set = ERR_ERASE | ERR_VPP;
          st_d    = ST_IDLE;
        end else if (resume_req) begin
          st_d   = ST_PULSE;
          ccnt_d = '0;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      ccnt_q  <= '0;
      pcnt_q  <= '0;
      err_q   <= '0;
      erase_q <= 1'b0;
      op_blk  <= '0;
      op_widx <= '0;
      op_data <= '0;
    end else begin
      st_q   <= st_d;
      ccnt_q <= ccnt_d;
      pcnt_q <= pcnt_d;
      err_q  <= (clr_status ? 3'b000 : err_q) | err_set;
      if (accept) begin
        erase_q <= (cmd_op == OP_ERASE);
        op_blk  <= cmd_blk;
        op_widx <= cmd_widx;
        op_data <= cmd_data;
      end
    end
  end

  assign status = {(st_q == ST_IDLE) || (st_q == ST_SUSP), st_q == ST_SUSP, err_q, 3'b000};

  a_r13_ready_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (status[7] && !status[6]));
  a_r12_sticky_errors: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_status |=> ((err_q & $past(err_q)) == $past(err_q)));
  a_r8_vpp_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !vpp_ok && !pwr_off) |=> (st_q == ST_IDLE && err_q[0]));
  a_r9_suspend_erase_only: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SUSP) |-> erase_q);
  a_r7_pulse_bound: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (pcnt_q <= limit));
  a_r11_suspend_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SUSP && (pwr_off || !vpp_ok)) |=> (st_q == ST_IDLE && err_q[2] && err_q[0]));
  a_r3_refused_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cmd_known && cmd_prot) |=> (st_q == ST_IDLE));
endmodule

// File: rtl/pe_sequencer.sv
module pe_sequencer
  import pe_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int WPB       = 4,
  parameter int PULSE_CYC = 4,
  parameter int PROG_MAX  = 5,
  parameter int ERASE_MAX = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [16:0]       cmd_addr,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic              suspend_req,
  input  logic              resume_req,
  input  logic              clr_status,
  input  logic              vpp_ok,
  input  logic [1:0]        rp_lvl,
  input  logic              wp,
  output logic [7:0]        status,
  input  logic [16:0]       rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int WIDX_W = $clog2(WPB);

  logic [BLK_W-1:0]  cmd_blk, op_blk, rd_blk;
  logic              cmd_prot, prog_en, erase_en, blk_erased;
  logic [WIDX_W-1:0] op_widx;
  logic [DATA_W-1:0] op_data, word_q;

  assign rd_blk = blk_of(rd_addr);

  pe_block_map u_map (
    .addr(cmd_addr), .vpp_ok(vpp_ok), .rp_lvl(rp_lvl), .wp(wp),
    .blk(cmd_blk), .prot(cmd_prot)
  );

  pe_ctrl #(
    .DATA_W(DATA_W), .WIDX_W(WIDX_W), .PULSE_CYC(PULSE_CYC),
    .PROG_MAX(PROG_MAX), .ERASE_MAX(ERASE_MAX)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_blk(cmd_blk), .cmd_widx(cmd_addr[WIDX_W-1:0]),
    .cmd_data(cmd_data), .cmd_prot(cmd_prot), .suspend_req(suspend_req),
    .resume_req(resume_req), .clr_status(clr_status), .vpp_ok(vpp_ok),
    .rp_lvl(rp_lvl), .word_q(word_q), .blk_erased(blk_erased),
    .op_blk(op_blk), .op_widx(op_widx), .op_data(op_data),
    .prog_en(prog_en), .erase_en(erase_en), .status(status)
  );

  pe_array #(.DATA_W(DATA_W), .WPB(WPB)) u_arr (
    .clk(clk), .rst_n(rst_n), .op_blk(op_blk), .op_widx(op_widx),
    .op_data(op_data), .prog_en(prog_en), .erase_en(erase_en),
    .word_q(word_q), .blk_erased(blk_erased),
    .rd_blk(rd_blk), .rd_widx(rd_addr[WIDX_W-1:0]), .rd_q(rd_data)
  );
endmodule

// File: tb/sim_pe_sequencer.sv
module sim_pe_sequencer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [1:0]  cmd_op = 2'b00;
  logic [16:0] cmd_addr = '0;
  logic [15:0] cmd_data = '0;
  logic        suspend_req = 1'b0, resume_req = 1'b0, clr_status = 1'b0;
  logic        vpp_ok = 1'b1;
  logic [1:0]  rp_lvl = 2'd1;
  logic        wp = 1'b1;
  logic [7:0]  status;
  logic [16:0] rd_addr = '0;
  logic [15:0] rd_data;
  int n_chk = 0, n_err = 0;

  always #5 clk = ~clk;

  pe_sequencer u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .suspend_req(suspend_req), .resume_req(resume_req), .clr_status(clr_status),
    .vpp_ok(vpp_ok), .rp_lvl(rp_lvl), .wp(wp), .status(status),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive at negedge, accept at next posedge, return at following negedge
  task automatic send(input logic [1:0] op, input logic [16:0] a, input logic [15:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 500; i++) begin
      if (status[7]) break;
      @(negedge clk);
    end
  endtask

  task automatic rd(input logic [16:0] a, output logic [15:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic clear();
    @(negedge clk); clr_status = 1'b1;
    @(negedge clk); clr_status = 1'b0;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    check("R1 status", status, 8'h80);
    check("R1 ready", cmd_ready, 1'b1);
    rd(17'h00000, d); check("R1 word 0", d, 16'hFFFF);
    rd(17'h1FFFF, d); check("R1 word top", d, 16'hFFFF);
  endtask

  task automatic t_program();
    logic [15:0] d;
    send(2'b01, 17'h04000, 16'h00FF); wait_ready();
    check("R4 status", status, 8'h80);
    rd(17'h04000, d); check("R4 word", d, 16'h00FF);
    send(2'b01, 17'h04000, 16'h000F); wait_ready();
    check("R4 status2", status, 8'h80);
    rd(17'h04000, d); check("R4 and", d, 16'h000F);
    rd(17'h04001, d); check("R4 neighbour", d, 16'hFFFF);
  endtask

  task automatic t_prog_fail();
    logic [15:0] d;
    send(2'b01, 17'h04000, 16'h0F0F); wait_ready();
    check("R5 status", status, 8'h90);
    rd(17'h04000, d); check("R5 word", d, 16'h000F);
    send(2'b01, 17'h04001, 16'h1234); wait_ready();
    check("R12 sticky", status, 8'h90);
    rd(17'h04001, d); check("R12 later op ran", d, 16'h1234);
    clear();
    check("R12 cleared", status, 8'h80);
  endtask

  task automatic t_protect();
    logic [15:0] d;
    wp = 1'b0; rp_lvl = 2'd1;
    send(2'b01, 17'h01FFF, 16'h0000);
    check("R3 boot refused", status, 8'h90);
    check("R3 ready", cmd_ready, 1'b1);
    rd(17'h01FFF, d); check("R2 boot unchanged", d, 16'hFFFF);
    clear();
    send(2'b01, 17'h02000, 16'h5555); wait_ready();
    check("R2 param writable", status, 8'h80);
    rd(17'h02000, d); check("R2 param word", d, 16'h5555);
    send(2'b10, 17'h00000, 16'h0000);
    check("R3 boot erase refused", status, 8'hA0);
    clear();
    rp_lvl = 2'd2;
    send(2'b01, 17'h00010, 16'hAAAA); wait_ready();
    check("R3 unlock status", status, 8'h80);
    rd(17'h00010, d); check("R3 unlock word", d, 16'hAAAA);
    rp_lvl = 2'd1; wp = 1'b1;
    vpp_ok = 1'b0;
    send(2'b01, 17'h03000, 16'h0000);
    check("R8 start vpp", status, 8'h88);
    rd(17'h03000, d); check("R8 start no change", d, 16'hFFFF);
    vpp_ok = 1'b1;
    clear();
  endtask

  task automatic t_erase();
    logic [15:0] d;
    send(2'b01, 17'h10000, 16'h1111); wait_ready();
    send(2'b01, 17'h10001, 16'h2222); wait_ready();
    send(2'b10, 17'h1ABCD, 16'h0000); wait_ready();
    check("R6 status", status, 8'h80);
    rd(17'h10000, d); check("R6 word0", d, 16'hFFFF);
    rd(17'h10001, d); check("R6 word1", d, 16'hFFFF);
    rd(17'h04000, d); check("R6 other block", d, 16'h000F);
  endtask

  task automatic t_erase_fail();
    logic [15:0] d;
    for (int i = 0; i < 4; i++) begin
      send(2'b01, 17'h03000 + 17'(i), 16'h0000); wait_ready();
    end
    send(2'b10, 17'h03002, 16'h0000); wait_ready();
    check("R7 status", status, 8'hA0);
    rd(17'h03000, d); check("R7 lowest restored", d, 16'hFFFF);
    rd(17'h03003, d); check("R7 last left", d, 16'h0000);
    clear();
  endtask

  task automatic t_vpp_run();
    logic [15:0] d;
    send(2'b01, 17'h04002, 16'h00FF);
    vpp_ok = 1'b0;
    @(negedge clk);
    check("R8 run abort", status, 8'h88);
    rd(17'h04002, d); check("R8 run no change", d, 16'hFFFF);
    vpp_ok = 1'b1;
    clear();
  endtask

  task automatic t_suspend();
    logic [15:0] d;
    for (int i = 0; i < 3; i++) begin
      send(2'b01, 17'h10000 + 17'(i), 16'h0000); wait_ready();
    end
    send(2'b10, 17'h10000, 16'h0000);
    check("R13 busy not ready", cmd_ready, 1'b0);
    suspend_req = 1'b1;
    @(negedge clk); suspend_req = 1'b0;
    check("R9 suspended", status, 8'hC0);
    check("R13 suspended not ready", cmd_ready, 1'b0);
    rd(17'h10000, d); check("R9 no pulse", d, 16'h0000);
    repeat (10) @(negedge clk);
    check("R9 held", status, 8'hC0);
    resume_req = 1'b1;
    @(negedge clk); resume_req = 1'b0;
    check("R10 resumed busy", status, 8'h00);
    wait_ready();
    check("R10 done", status, 8'h80);
    rd(17'h10002, d); check("R10 erased", d, 16'hFFFF);
  endtask

  task automatic t_susp_last();
    send(2'b10, 17'h10000, 16'h0000);
    repeat (4) @(posedge clk);
    @(negedge clk); suspend_req = 1'b1;
    @(negedge clk); suspend_req = 1'b0;
    check("R9 last cycle completes", status, 8'h80);
    repeat (2) @(negedge clk);
    check("R9 stays done", status, 8'h80);
  endtask

  task automatic t_susp_abort();
    send(2'b01, 17'h10000, 16'h0000); wait_ready();
    send(2'b10, 17'h10000, 16'h0000);
    suspend_req = 1'b1;
    @(negedge clk); suspend_req = 1'b0;
    check("R11 suspended", status, 8'hC0);
    vpp_ok = 1'b0;
    @(negedge clk);
    check("R11 vpp abort", status, 8'hA8);
    vpp_ok = 1'b1;
    clear();
    send(2'b10, 17'h10000, 16'h0000);
    suspend_req = 1'b1;
    @(negedge clk); suspend_req = 1'b0;
    rp_lvl = 2'd0;
    @(negedge clk);
    check("R11 power-down abort", status, 8'hA8);
    check("R13 power-down not ready", cmd_ready, 1'b0);
    rp_lvl = 2'd1;
    clear();
    check("R12 clear after abort", status, 8'h80);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_program();
    t_prog_fail();
    t_protect();
    t_erase();
    t_erase_fail();
    t_vpp_run();
    t_suspend();
    t_susp_last();
    t_susp_abort();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule